// File: doc/BRIEF.md
# Wake-Up Input Controller with Cyclic Sense

This block watches four external wake-up lines while the device rests in one of its two low-power modes (Sleep or Stop) and decides when to wake it. Software sets it up in Normal or Standby mode: a two-bit sensitivity code for each pair of lines, a four-bit low-power control field that chooses between direct and cyclic sensing, and a forced-wake enable. In direct sensing the lines are compared with their previous value on every clock. In cyclic sensing a frame timer drives a high-side bias enable for a short window at the start of each frame. The lines are sampled only on the last cycle of that window.

A detected event sets a sticky source bit in a status register. A read strobe clears the register. The event also produces a one-cycle request: a supply turn-on request when the device is in Sleep, or an interrupt when it is in Stop. A forced wake is also available. It fires at the end of every timer frame and can never be combined with cyclic sensing. The line inputs are assumed to be already synchronized to `clk`, which is the low-power clock.

Top module: `wake_ctrl`

## Requirements
- R1: `lvl_o` always equals the current `wake_i` levels, in every power mode.
- R2: The sensitivity codes apply per pair: `cfg_sens_i[1:0]` covers lines 0 and 1, and `cfg_sens_i[3:2]` covers lines 2 and 3. Code 00 disables the pair, 01 reacts to a low-to-high change, 10 reacts to a high-to-low change, and 11 reacts to either. A hit on line n sets `status_o[n]` at the clock edge that sees the change.
- R3: Bits 3 and 0 of the control field select the mode. Both cleared (0xx0) selects direct sensing, with comparison on every clock in Sleep/Stop. Both set (1xx1) selects cyclic sensing for all four lines. Any other pattern disables line wake-ups.
- R4: In cyclic mode, during Sleep/Stop, `bias_o` is high for the first ON_LEN cycles of each PERIOD-cycle frame. Frames start when low power is entered. Lines are sampled only on the last bias cycle, so a change made while the bias is off is not seen until the next frame.
- R5: With forced wake enabled and cyclic mode not selected, the last cycle of every frame in Sleep/Stop sets `status_o[4]`.
- R6: A configuration write that selects cyclic mode stores forced wake as disabled, whatever `cfg_force_i` says.
- R7: `mode_i` is encoded as 00 Normal, 01 Standby, 10 Sleep, 11 Stop. `cfg_we_i` is accepted only in Normal or Standby and is ignored in Sleep or Stop.
- R8: An event produces a one-cycle `vdd_req_o` pulse if it was detected in Sleep, or a one-cycle `irq_o` pulse if it was detected in Stop. The pulse appears in the cycle after the detecting edge.
- R9: `status_o` bits stay set until `rd_i` is high at a clock edge, which clears them. An event at that same edge still sets its bit.
- R10: After reset, `status_o`, `irq_o`, `vdd_req_o` and `bias_o` are all 0.
- R11: No line change sets a status bit while `mode_i` is Normal or Standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | low-power clock |
| rst_n | input | 1 | active-low asynchronous reset |
| mode_i | input | 2 | power mode (00 Normal, 01 Standby, 10 Sleep, 11 Stop) |
| cfg_we_i | input | 1 | configuration write strobe |
| cfg_lpc_i | input | 4 | low-power control field (bit 3 bias enable, bit 0 auto bias) |
| cfg_sens_i | input | 4 | pair sensitivity codes |
| cfg_force_i | input | 1 | forced-wake enable |
| wake_i | input | 4 | synchronized wake-up line levels |
| rd_i | input | 1 | status read strobe, clears status |
| lvl_o | output | 4 | live line levels |
| status_o | output | 5 | latched sources: bits 3:0 lines, bit 4 forced |
| bias_o | output | 1 | high-side bias switch enable |
| vdd_req_o | output | 1 | supply turn-on request pulse |
| irq_o | output | 1 | interrupt pulse |

## Verification
A stale previous-level register shows up as a missing or spurious status bit one edge after the line changes. A timer that is off by one in cyclic mode shows up in two ways: a wrong number of bias cycles per frame, and a line change that is caught one frame early or late. Such an error becomes visible within one PERIOD. A wrong mode decode or a wrong write gate appears as a wake where none is expected, or as a missing wake. A wrong forced-wake rule appears as a forced bit or an interrupt after a frame has passed. The bench checks each of these at the ports, at the exact cycle where the effect should appear.

// File: rtl/wake_pkg.sv
package wake_pkg;
    typedef enum logic [1:0] {
        PM_NORMAL  = 2'b00,
        PM_STANDBY = 2'b01,
        PM_SLEEP   = 2'b10,
        PM_STOP    = 2'b11
    } pmode_e;

    typedef struct packed {
        logic [3:0] lpc;
        logic [3:0] sens;
        logic       force_en;
    } wcfg_t;
endpackage

// File: rtl/wake_cyc_timer.sv
module wake_cyc_timer #(
    parameter int PERIOD = 8,
    parameter int ON_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic win_o,
    output logic sample_o,
    output logic wrap_o
);
    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i)
            cnt_d = '0;
        else if (cnt_q == CW'(PERIOD - 1))
            cnt_d = '0;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign win_o    = run_i && (cnt_q < CW'(ON_LEN));
    assign sample_o = run_i && (cnt_q == CW'(ON_LEN - 1));
    assign wrap_o   = run_i && (cnt_q == CW'(PERIOD - 1));

    // R4: frame counter stays inside one frame
    p_frame_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(PERIOD - 1));
    // R4: a stopped timer restarts from the frame start
    p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> cnt_q == '0);
endmodule

// File: rtl/wake_edge_det.sv
module wake_edge_det (
    input  logic       prev_i,
    input  logic       cur_i,
    input  logic [1:0] sens_i,
    output logic       hit_o
);
    always_comb begin
        hit_o = (sens_i[0] & ~prev_i & cur_i) | (sens_i[1] & prev_i & ~cur_i);
    end
endmodule

// File: rtl/wake_ctrl.sv
module wake_ctrl
    import wake_pkg::*;
#(
    parameter int NLINE  = 4,
    parameter int PERIOD = 8,
    parameter int ON_LEN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic             cfg_we_i,
    input  logic [3:0]       cfg_lpc_i,
    input  logic [3:0]       cfg_sens_i,
    input  logic             cfg_force_i,
    input  logic [NLINE-1:0] wake_i,
    input  logic             rd_i,
    output logic [NLINE-1:0] lvl_o,
    output logic [NLINE:0]   status_o,
    output logic             bias_o,
    output logic             vdd_req_o,
    output logic             irq_o
);
    typedef struct packed {
        wcfg_t            cfg;
        logic [NLINE-1:0] prev;
        logic [NLINE:0]   src;
        logic             irq;
        logic             vdd;
    } st_t;

    st_t st_d, st_q;

    logic             lowp, is_dir, is_cyc;
    logic             win, sample, wrap, strobe, force_hit;
    logic [NLINE-1:0] hits;
    logic [NLINE:0]   ev;

    assign lowp   = mode_i[1];
    assign is_dir = !st_q.cfg.lpc[3] && !st_q.cfg.lpc[0];
    assign is_cyc =  st_q.cfg.lpc[3] &&  st_q.cfg.lpc[0];

    wake_cyc_timer #(.PERIOD(PERIOD), .ON_LEN(ON_LEN)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (lowp),
        .win_o    (win),
        .sample_o (sample),
        .wrap_o   (wrap)
    );

    for (genvar g = 0; g < NLINE; g++) begin : g_line
        wake_edge_det i_edge (
            .prev_i (st_q.prev[g]),
            .cur_i  (wake_i[g]),
            .sens_i (st_q.cfg.sens[2*(g/2) +: 2]),
            .hit_o  (hits[g])
        );
    end

    always_comb begin
        st_d      = st_q;
        strobe    = lowp && (is_dir || (is_cyc && sample));
        force_hit = lowp && st_q.cfg.force_en && wrap;
        ev        = {force_hit, hits & {NLINE{strobe}}};

        if (!lowp || strobe)
            st_d.prev = wake_i;

        if (cfg_we_i && !lowp) begin
            st_d.cfg.lpc      = cfg_lpc_i;
            st_d.cfg.sens     = cfg_sens_i;
            st_d.cfg.force_en = cfg_force_i && !(cfg_lpc_i[3] && cfg_lpc_i[0]);
        end

        st_d.src = (rd_i ? '0 : st_q.src) | ev;
        st_d.irq = (|ev) && (mode_i == PM_STOP);
        st_d.vdd = (|ev) && (mode_i == PM_SLEEP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o     = wake_i;
    assign status_o  = st_q.src;
    assign bias_o    = win && is_cyc;
    assign vdd_req_o = st_q.vdd;
    assign irq_o     = st_q.irq;

    // R7: configuration frozen while in a low-power mode
    p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode_i[1]) |-> $stable(st_q.cfg));
    // R6: forced wake never coexists with cyclic sensing
    p_force_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.cfg.force_en && is_cyc));
    // R8: interrupt only after Stop, supply request only after Sleep
    p_irq_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(mode_i) == PM_STOP);
    p_vdd_sleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vdd_req_o |-> $past(mode_i) == PM_SLEEP);
    p_one_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_o, vdd_req_o}));
    // R11: no new source bits appear outside low power
    p_no_wake_awake_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mode_i[1]) |-> (status_o & ~$past(status_o)) == '0);
    // R4: bias only during low power
    p_bias_lowp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bias_o |-> mode_i[1]);
endmodule

// File: tb/test_wake_ctrl.sv
`timescale 1ns/1ps
module test_wake_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_lpc = 4'b0;
    logic [3:0] cfg_sens = 4'b0;
    logic       cfg_force = 1'b0;
    logic [3:0] wake = 4'b0;
    logic       rd = 1'b0;
    logic [3:0] lvl;
    logic [4:0] status;
    logic       bias, vdd_req, irq;

    int n_chk = 0;
    int n_bad = 0;
    int n_irq = 0;
    int n_vdd = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wake_ctrl i_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .cfg_we_i(cfg_we),
        .cfg_lpc_i(cfg_lpc), .cfg_sens_i(cfg_sens), .cfg_force_i(cfg_force),
        .wake_i(wake), .rd_i(rd), .lvl_o(lvl), .status_o(status),
        .bias_o(bias), .vdd_req_o(vdd_req), .irq_o(irq)
    );

    always @(negedge clk) begin
        if (irq)     n_irq++;
        if (vdd_req) n_vdd++;
    end

    // {stop, sens[3:0], start[3:0], change[3:0], expected src[3:0]}
    localparam logic [16:0] VEC [0:7] = '{
        {1'b0, 4'b0101, 4'b0000, 4'b0001, 4'b0001},
        {1'b1, 4'b0101, 4'b0001, 4'b0000, 4'b0000},
        {1'b1, 4'b1010, 4'b1111, 4'b1011, 4'b0100},
        {1'b0, 4'b1111, 4'b0000, 4'b1001, 4'b1001},
        {1'b1, 4'b0000, 4'b0000, 4'b1111, 4'b0000},
        {1'b0, 4'b1001, 4'b1100, 4'b0011, 4'b1111},
        {1'b1, 4'b0100, 4'b0000, 4'b1111, 4'b1100},
        {1'b0, 4'b0011, 4'b0011, 4'b0100, 4'b0011}
    };

    task automatic check(input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", what, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [3:0] lpc, input logic [3:0] sens, input logic frc);
        cfg_lpc = lpc; cfg_sens = sens; cfg_force = frc; cfg_we = 1'b1;
        step(1);
        cfg_we = 1'b0;
    endtask

    task automatic clear_status();
        rd = 1'b1; step(1); rd = 1'b0;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int i0, v0;
        step(3);
        // R10: reset state
        check("R10 status after reset", int'(status), 0);
        check("R10 irq/vdd/bias after reset", int'({irq, vdd_req, bias}), 0);
        rst_n = 1'b1;
        step(2);

        // R1: live levels
        wake = 4'b1010; #1;
        check("R1 lvl", int'(lvl), 10);
        mode = 2'b11; wake = 4'b0110; #1;
        check("R1 lvl in Stop", int'(lvl), 6);
        mode = 2'b00; wake = 4'b0000;
        step(2);

        // R2/R8 vector table in direct mode
        for (int k = 0; k < 8; k++) begin
            logic [16:0] v;
            v = VEC[k];
            mode = 2'b00;
            write_cfg(4'b0000, v[15:12], 1'b0);
            wake = v[11:8];
            step(2);
            clear_status();
            i0 = n_irq; v0 = n_vdd;
            mode = v[16] ? 2'b11 : 2'b10;
            step(2);
            wake = v[7:4];
            step(3);
            check($sformatf("R2 vector %0d status", k), int'(status), int'({1'b0, v[3:0]}));
            check($sformatf("R8 vector %0d irq pulses", k), n_irq - i0,
                  (v[16] && v[3:0] != 0) ? 1 : 0);
            check($sformatf("R8 vector %0d vdd pulses", k), n_vdd - v0,
                  (!v[16] && v[3:0] != 0) ? 1 : 0);
            mode = 2'b00;
            step(1);
        end

        // R9: read clears; event at same edge survives
        mode = 2'b00; wake = 4'b0000;
        write_cfg(4'b0000, 4'b1111, 1'b0);
        step(1); clear_status();
        mode = 2'b10; step(2);
        wake = 4'b0001; step(2);
        check("R9 sticky bit", int'(status), 1);
        step(3);
        check("R9 still sticky", int'(status), 1);
        rd = 1'b1; wake = 4'b0011; step(1); rd = 1'b0;
        check("R9 read with simultaneous event", int'(status), 2);
        clear_status();
        check("R9 read clears", int'(status), 0);

        // R11: Normal/Standby ignore line changes
        mode = 2'b01; step(2);
        wake = 4'b1100; step(3);
        check("R11 no wake in Standby", int'(status), 0);
        mode = 2'b00; wake = 4'b0000; step(3);
        check("R11 no wake in Normal", int'(status), 0);

        // R7: writes in Sleep ignored
        write_cfg(4'b0000, 4'b0000, 1'b0);
        mode = 2'b10; step(2);
        write_cfg(4'b0000, 4'b1111, 1'b0);
        step(1);
        wake = 4'b1111; step(3);
        check("R7 write ignored in Sleep", int'(status), 0);
        mode = 2'b00; wake = 4'b0000; step(2);

        // R3: mixed control pattern disables line wake-ups
        write_cfg(4'b1000, 4'b1111, 1'b0);
        step(1);
        mode = 2'b10; step(2);
        wake = 4'b0101; step(20);
        check("R3 pattern 1xx0 no wake", int'(status), 0);
        mode = 2'b00; wake = 4'b0000; step(2);

        // R4: cyclic sensing, bias window and delayed sampling
        write_cfg(4'b1001, 4'b1111, 1'b0);
        step(1); clear_status();
        check("R4 bias low in Normal", int'(bias), 0);
        i0 = n_irq;
        begin
            int hi;
            hi = 0;
            mode = 2'b11;
            for (int j = 0; j < 8; j++) begin
                #1;
                if (bias) hi++;
                @(negedge clk);
            end
            check("R4 bias cycles per frame", hi, 2);
        end
        step(2);
        wake = 4'b0001;
        step(3);
        check("R4 change not seen before next sample", int'(status), 0);
        step(8);
        check("R4 change seen at next sample", int'(status), 1);
        check("R4/R8 cyclic irq count", n_irq - i0, 1);
        mode = 2'b00; wake = 4'b0000; step(2); clear_status();

        // R5: forced wake at frame end
        write_cfg(4'b0000, 4'b0000, 1'b1);
        step(1); clear_status();
        i0 = n_irq;
        mode = 2'b11; step(6);
        check("R5 no forced wake before frame end", int'(status), 0);
        step(4);
        check("R5 forced wake bit", int'(status), 16);
        check("R5 forced irq", n_irq - i0, 1);
        mode = 2'b00; step(2); clear_status();

        // R6: forced wake rejected with cyclic mode
        write_cfg(4'b1001, 4'b0000, 1'b1);
        step(1); clear_status();
        i0 = n_irq;
        mode = 2'b11; step(25);
        check("R6 force rejected with cyclic", int'(status), 0);
        check("R6 no irq", n_irq - i0, 0);
        mode = 2'b00; step(2);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule